// File: doc/BRIEF.md
# Ordered-Port True Dual-Port RAM

A synchronous memory with two independent access ports, A and B, that share one clock. Either port can read or write any word in the same cycle as the other. Each port has an enable, a write-enable bit for each byte lane, an address, write data and a registered read output. Each read output has a synchronous reset that clears it to zero.

A port that writes in a cycle keeps its read output unchanged (no-change behaviour). Both ports can reach the same word in one cycle. In that case the memory acts as if port A's access happens first and port B's access happens second. A read on B sees bytes that A has just written. A read on A sees the contents from before B's write. When both ports write the same word, B's bytes land last.

The data width is a multiple of eight. The depth is a power of two. Both are parameters.

Top module: `ordered_tdp_ram`

## Requirements
- R1: Both ports run on the single clock `clk`. Each port can write any address, and a word written by either port can be read back by either port.
- R2: In a cycle where a port has its enable high and at least one write-enable bit set, that port's read output keeps its previous value.
- R3: In a cycle where a port has its enable high and all write-enable bits clear, that port's read output shows the addressed word after the next rising clock edge.
- R4: Port A writes and port B reads the same address in the same cycle. B's output then holds A's new byte in each lane that A enables, and the stored byte in every other lane.
- R5: Port A reads and port B writes the same address in the same cycle. A's output is the word as it was before B's write.
- R6: A port whose enable is low neither reads nor writes, whatever its write-enable bits are. Its read output holds, and memory contents are unchanged.
- R7: Write-enable bit i controls byte lane i, which is data bits 8i+7 down to 8i. A write changes only the enabled lanes of the addressed word.
- R8: While `rst` is high, both read outputs become all zeros at the next clock edge, even if a read is requested. Reset does not alter the stored words.
- R9: Both ports write the same address in one cycle. Port B's byte wins in each lane both ports enable. Lanes enabled by only one port take that port's byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst | input | 1 | Synchronous active-high clear of both read outputs |
| a_en | input | 1 | Port A access enable |
| a_we | input | DATA_W/8 | Port A byte-lane write enables |
| a_addr | input | log2(DEPTH) | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_en | input | 1 | Port B access enable |
| b_we | input | DATA_W/8 | Port B byte-lane write enables |
| b_addr | input | log2(DEPTH) | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge. The forwarding property assumes that a full-word write on A paired with a read on B is judged against A's data from that same cycle.

The bench changes all inputs only on the falling edge, so no input moves near the sampling edge. It writes every address before any read, so no check depends on the memory's power-up contents.

Collision stimulus comes from two sources:
- directed cases over every lane mask;
- a random phase whose addresses are confined to four words, so that same-address cycles happen often.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  localparam int unsigned LANE_W = 8;
  typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/tdp_port_ctrl.sv
module tdp_port_ctrl #(
  parameter int unsigned LANES = 4
) (
  input  logic             en,
  input  logic [LANES-1:0] we,
  output logic [LANES-1:0] lane_wr,
  output logic             rd_load
);
  // A cycle is a write cycle if any lane is enabled; otherwise an enabled read.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_wr[i] = en & we[i];
  end
  assign rd_load = en & ~(|we);
endmodule

// File: rtl/tdp_lane_bank.sv
module tdp_lane_bank
  import tdp_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [ADDR_W-1:0] a_addr,
  input  lane_t             a_wd,
  output lane_t             a_q,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [ADDR_W-1:0] b_addr,
  input  lane_t             b_wd,
  output lane_t             b_q
);
  lane_t mem [DEPTH];
  logic  b_sees_a;

  // B is ordered after A: a same-address A write is visible to B's read.
  assign b_sees_a = a_wr && (a_addr == b_addr);

  // Later nonblocking assignment wins, so B overrides A on a shared word.
  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wd;
    if (b_wr) mem[b_addr] <= b_wd;
  end

  always_ff @(posedge clk) begin
    if (rst)       a_q <= '0;
    else if (a_rd) a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)       b_q <= '0;
    else if (b_rd) b_q <= b_sees_a ? a_wd : mem[b_addr];
  end
endmodule

// File: rtl/ordered_tdp_ram.sv
module ordered_tdp_ram
  import tdp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned LANES  = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic [LANES-1:0]  a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic [LANES-1:0]  b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  logic [LANES-1:0] a_lane_wr, b_lane_wr;
  logic             a_rd, b_rd;

  tdp_port_ctrl #(.LANES(LANES)) u_ctrl_a (
    .en(a_en), .we(a_we), .lane_wr(a_lane_wr), .rd_load(a_rd)
  );
  tdp_port_ctrl #(.LANES(LANES)) u_ctrl_b (
    .en(b_en), .we(b_we), .lane_wr(b_lane_wr), .rd_load(b_rd)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_bank
    tdp_lane_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .a_wr   (a_lane_wr[l]),
      .a_rd   (a_rd),
      .a_addr (a_addr),
      .a_wd   (a_wdata[l*LANE_W +: LANE_W]),
      .a_q    (a_rdata[l*LANE_W +: LANE_W]),
      .b_wr   (b_lane_wr[l]),
      .b_rd   (b_rd),
      .b_addr (b_addr),
      .b_wd   (b_wdata[l*LANE_W +: LANE_W]),
      .b_q    (b_rdata[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/ordered_tdp_ram_checker.sv
module ordered_tdp_ram_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              a_en,
  input logic [LANES-1:0]  a_we,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_wdata,
  input logic [DATA_W-1:0] a_rdata,
  input logic              b_en,
  input logic [LANES-1:0]  b_we,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_wdata,
  input logic [DATA_W-1:0] b_rdata
);
  logic seen_edge = 1'b0;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  // R2: a write cycle leaves the port's own output untouched
  a_r2_a_write_holds: assert property (@(posedge clk) disable iff (rst)
    (a_en && |a_we) |=> $stable(a_rdata));
  a_r2_b_write_holds: assert property (@(posedge clk) disable iff (rst)
    (b_en && |b_we) |=> $stable(b_rdata));

  // R6: a disabled port keeps its output
  a_r6_a_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !a_en |=> $stable(a_rdata));
  a_r6_b_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !b_en |=> $stable(b_rdata));

  // R8: reset clears both outputs on the following edge
  a_r8_reset_clears: assert property (@(posedge clk) disable iff (!seen_edge)
    rst |=> (a_rdata == '0 && b_rdata == '0));

  // R4: full-word A write with a same-address B read forwards A's data to B
  a_r4_forward_to_b: assert property (@(posedge clk) disable iff (rst)
    (a_en && &a_we && b_en && b_we == '0 && a_addr == b_addr)
      |=> b_rdata == $past(a_wdata));
endmodule

bind ordered_tdp_ram ordered_tdp_ram_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)
) u_chk (.*);

// File: tb/tb_ordered_tdp_ram.sv
module tb_ordered_tdp_ram;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int LN = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          a_en = 0, b_en = 0;
  logic [LN-1:0] a_we = '0, b_we = '0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;

  ordered_tdp_ram #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] exp_a = '0, exp_b = '0;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [LN-1:0] we);
    logic [DW-1:0] r = old;
    for (int i = 0; i < LN; i++) if (we[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  task automatic check(string tag, string port, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s port %s: got %h expected %h", tag, port, got, exp);
    end
  endtask

  // One cycle: drive at falling edge, model A then B, compare after the next rising edge.
  task automatic cyc(bit r, bit ae, logic [LN-1:0] awe, logic [AW-1:0] aa, logic [DW-1:0] ad,
                     bit be, logic [LN-1:0] bwe, logic [AW-1:0] ba, logic [DW-1:0] bd, string tag);
    logic [DW-1:0] na = exp_a, nb = exp_b;
    rst = r; a_en = ae; a_we = awe; a_addr = aa; a_wdata = ad;
    b_en = be; b_we = bwe; b_addr = ba; b_wdata = bd;
    if (ae && awe == '0) na = model[aa];
    if (ae && awe != '0) model[aa] = merge(model[aa], ad, awe);
    if (be && bwe == '0) nb = model[ba];
    if (be && bwe != '0) model[ba] = merge(model[ba], bd, bwe);
    if (r) begin na = '0; nb = '0; end
    exp_a = na; exp_b = nb;
    @(posedge clk);
    @(negedge clk);
    check(tag, "A", a_rdata, exp_a);
    check(tag, "B", b_rdata, exp_b);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R8: reset state
    repeat (2) cyc(1, 0, '0, '0, '0, 0, '0, '0, '0, "R8 reset");
    // R1: fill by A, read by B
    for (int i = 0; i < DEPTH; i++)
      cyc(0, 1, '1, AW'(i), DW'(16'hA500 + i * 16'h0111), 0, '0, '0, '0, "R1 fill A");
    for (int i = 0; i < DEPTH; i++)
      cyc(0, 0, '0, '0, '0, 1, '0, AW'(i), '0, "R1 R3 read B");
    // R1: rewrite half by B, read by A
    for (int i = 0; i < DEPTH; i += 2)
      cyc(0, 0, '0, '0, '0, 1, '1, AW'(i), DW'(16'h3C00 ^ (i * 16'h1021)), "R1 fill B");
    for (int i = 0; i < DEPTH; i++)
      cyc(0, 1, '0, AW'(i), '0, 0, '0, '0, '0, "R1 R3 read A");
    // R2: write cycles keep outputs
    cyc(0, 1, '0, 4'd3, '0, 1, '0, 4'd4, '0, "R3 load");
    cyc(0, 1, 2'b01, 4'd5, 16'h1111, 1, 2'b10, 4'd6, 16'h2222, "R2 write holds");
    cyc(0, 1, '1, 4'd7, 16'h3333, 1, '1, 4'd8, 16'h4444, "R2 write holds");
    // R6: disabled port with write enables set
    cyc(0, 0, '1, 4'd9, 16'hDEAD, 0, '1, 4'd10, 16'hBEEF, "R6 disabled");
    cyc(0, 1, '0, 4'd9, '0, 1, '0, 4'd10, '0, "R6 contents kept");
    // R7: every lane mask on several words
    for (int m = 1; m < 4; m++)
      for (int i = 0; i < 4; i++) begin
        cyc(0, 1, LN'(m), AW'(i + 4 * m), DW'(16'hF00F ^ (m << 4) ^ i), 0, '0, '0, '0, "R7 lane write");
        cyc(0, 0, '0, '0, '0, 1, '0, AW'(i + 4 * m), '0, "R7 lane readback");
      end
    // Collisions on one address with every mask
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < DEPTH; i += 5) begin
        cyc(0, 1, LN'(m == 0 ? 3 : m), AW'(i), DW'(16'h8100 + m * 16'h0203 + i), 1, '0, AW'(i), '0, "R4 A write B read");
        cyc(0, 1, '0, AW'(i), '0, 1, LN'(m == 0 ? 3 : m), AW'(i), DW'(16'h4200 + m * 16'h0305 + i), "R5 A read B write");
        cyc(0, 1, LN'(m), AW'(i), DW'(16'hAAAA ^ i), 1, LN'(3 - m), AW'(i), DW'(16'h5555 ^ i), "R9 both write");
        cyc(0, 1, 2'b11, AW'(i), DW'(16'h1357 + i), 1, LN'(m == 0 ? 1 : m), AW'(i), DW'(16'h9BDF - i), "R9 B wins");
        cyc(0, 1, '0, AW'(i), '0, 1, '0, AW'(i), '0, "R1 both read");
      end
    // R8: reset beats a read, contents survive
    cyc(0, 1, '0, 4'd1, '0, 1, '0, 4'd2, '0, "R3 load");
    cyc(1, 1, '0, 4'd3, '0, 1, '0, 4'd4, '0, "R8 reset over read");
    cyc(0, 1, '0, 4'd1, '0, 1, '0, 4'd2, '0, "R8 contents kept");
    // Random traffic confined to four words to force collisions
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] r = $urandom;
      cyc(r[31:28] == 0, r[0], LN'(r[1] ? r[3:2] : 0), AW'(r[5:4]), DW'(r[21:6]),
          r[22], LN'(r[23] ? r[25:24] : 0), AW'(r[27:26]), DW'(r[15:0] ^ 16'h6B6B), "R3 random");
    end
    finish_run();
  end
endmodule